// File: doc/BRIEF.md
# Streaming 3x3 Sharpening Filter

This block sharpens a raster stream of 8-bit grayscale pixels. Each accepted pixel comes with a valid qualifier and with frame-start, line-start and line-end markers. The block forms a 3x3 neighbourhood around every pixel from two internal line stores and a small column window. Samples that fall outside the frame are filled by repeating the nearest edge pixel. It weights the neighbourhood with a sharpening kernel, applies a fixed output gain, rounds and clamps the result. It then emits one 8-bit pixel per input pixel, with its own valid, line-start and line-end markers.

The kernel is a centre impulse minus a Laplacian with shape 0.2, divided by its largest magnitude so that each weight lies in [-1, 1]. The weights are stored as signed Q4.12 constants: centre +4096, the four edge neighbours -630 each and the four corner neighbours -158 each. A gain of 4 restores the scale lost by that division. Output row r leaves while input row r+1 arrives. The last row is produced from stored data once the input frame has ended.

Sequencing is a five-state machine:
- IDLE waits for a frame start and moves to PRIME on a pixel that carries both frame-start and line-start.
- PRIME stores the first row and moves to STREAM on its line end.
- STREAM filters one row behind the input and moves to TAIL on each line end.
- TAIL emits the last column of a row. It returns to STREAM while input rows remain, goes to DRAIN after the final input row, and goes to IDLE after the drained row.
- DRAIN generates the final output row by itself and moves to TAIL on its last column.

Top module: `sharpen3x3`

## Requirements
- R1: While reset is held and in the first cycle after it, out_valid, out_sol and out_eol are 0.
- R2: For centre C, sum E of the up/down/left/right neighbours and sum K of the four diagonal neighbours, let A = 4096*C - 630*E - 158*K. Each output pixel is floor((A + 512) / 1024), which is A times 4 scaled down by 2^12 and rounded to nearest with halves upward, and then clamped to 0..255.
- R3: Results below 0 leave as 0 and results above 255 leave as 255.
- R4: In column 0 the left neighbours repeat column 0, and in the last column the right neighbours repeat the last column.
- R5: In row 0 the upper neighbours repeat row 0, and in the last row (FRAME_H-1) the lower neighbours repeat that row.
- R6: Each frame yields LINE_W*FRAME_H output pixels in raster order. out_sol is 1 exactly on column 0 and out_eol is 1 exactly on column LINE_W-1, each only together with out_valid.
- R7: In IDLE, a pixel that does not carry in_valid, in_sof and in_sol together starts nothing and produces no output.
- R8: The output pixel at row r-1, column c-1 is valid exactly two cycles after the clock edge that accepts input pixel (r, c). Cycles with in_valid low stall the pipeline without altering any result.
- R9: A row's last column is emitted in the cycle after the one holding the row's preceding column, and out_valid is 0 in the cycle after out_eol. The source leaves at least one cycle without a pixel after each line end and sends no pixels while the final row drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input pixel qualifier |
| in_sof | input | 1 | First pixel of a frame |
| in_sol | input | 1 | First pixel of a line |
| in_eol | input | 1 | Last pixel of a line |
| in_pix | input | 8 | Input grayscale pixel |
| out_valid | output | 1 | Output pixel qualifier |
| out_sol | output | 1 | Output pixel is column 0 |
| out_eol | output | 1 | Output pixel is the last column |
| out_pix | output | 8 | Sharpened pixel |

## Verification
The bench sends several whole frames on a small 8x6 configuration and predicts every output pixel arithmetically with clamped indices. It goes after the four image borders and corners, where a design that mixes up replication would blend in stale line-store data or zeros. It also goes after a 0/255 checkerboard that drives both clamps, where a missing clamp would wrap around to a dark or bright value. Frames with dropouts in the valid qualifier expose a window that shifts on idle cycles. Measuring the two-cycle latency and checking the marker positions catches an off-by-one in the generated tail column or in the drained final row. Junk pixels before a frame start must leave the output silent.

// File: rtl/sharp_pkg.sv
package sharp_pkg;
    localparam int PIX_W = 8;
    typedef logic [PIX_W-1:0] pix_t;

    // one image column of the 3x3 neighbourhood
    typedef struct packed {
        pix_t up;
        pix_t mid;
        pix_t dn;
    } colv_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRIME,
        ST_STREAM,
        ST_TAIL,
        ST_DRAIN
    } st_t;

    // Q4.12 weights after division by the largest magnitude
    localparam int COEF_FRAC = 12;
    localparam int GAIN_LOG2 = 2;
    localparam int K_CTR  = 4096;
    localparam int K_EDGE = -630;
    localparam int K_CORN = -158;
endpackage

// File: rtl/sharp_linebuf.sv
module sharp_linebuf
    import sharp_pkg::*;
#(
    parameter int LINE_W = 64,
    parameter int DEPTH  = 2,
    localparam int AW    = $clog2(LINE_W)
) (
    input  logic                   clk,
    input  logic                   we,
    input  logic [AW-1:0]          addr,
    input  pix_t                   din,
    output logic [DEPTH*PIX_W-1:0] taps
);
    pix_t rd [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_ln
        pix_t mem [LINE_W];
        pix_t wdat;
        if (k == 0) begin : g_head
            assign wdat = din;
        end else begin : g_chain
            assign wdat = rd[k-1];
        end
        assign rd[k] = mem[addr];
        assign taps[k*PIX_W +: PIX_W] = rd[k];
        always_ff @(posedge clk) begin
            if (we) mem[addr] <= wdat;
        end
    end
endmodule

// File: rtl/sharp_hwin.sv
module sharp_hwin
    import sharp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  shift,
    input  logic  first,
    input  colv_t nv,
    output colv_t prv,
    output colv_t cur
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prv <= '0;
            cur <= '0;
        end else if (shift) begin
            cur <= nv;
            // column 0 seeds both slots so the left edge repeats itself
            prv <= first ? nv : cur;
        end
    end
endmodule

// File: rtl/sharp_mac.sv
module sharp_mac
    import sharp_pkg::*;
#(
    parameter int ACC_W = 24
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_vld,
    input  logic  in_sol,
    input  logic  in_eol,
    input  colv_t lft,
    input  colv_t ctr,
    input  colv_t rgt,
    output logic  o_vld,
    output logic  o_sol,
    output logic  o_eol,
    output pix_t  o_pix
);
    localparam int SHIFT = COEF_FRAC - GAIN_LOG2;
    localparam int HALF  = 1 << (SHIFT - 1);
    localparam int PMAX  = (1 << PIX_W) - 1;

    int sum_e, sum_k, acc_i, scaled;
    logic signed [ACC_W-1:0] acc_q;
    logic v1_q, s1_q, e1_q;

    always_comb begin
        sum_e = int'(ctr.up) + int'(ctr.dn) + int'(lft.mid) + int'(rgt.mid);
        sum_k = int'(lft.up) + int'(lft.dn) + int'(rgt.up) + int'(rgt.dn);
        acc_i = K_CTR * int'(ctr.mid) + K_EDGE * sum_e + K_CORN * sum_k;
        scaled = (int'(acc_q) + HALF) >>> SHIFT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            v1_q  <= 1'b0;
            s1_q  <= 1'b0;
            e1_q  <= 1'b0;
            o_vld <= 1'b0;
            o_sol <= 1'b0;
            o_eol <= 1'b0;
            o_pix <= '0;
        end else begin
            v1_q  <= in_vld;
            s1_q  <= in_vld && in_sol;
            e1_q  <= in_vld && in_eol;
            if (in_vld) acc_q <= ACC_W'(acc_i);
            o_vld <= v1_q;
            o_sol <= s1_q;
            o_eol <= e1_q;
            if (v1_q) begin
                if (scaled < 0)         o_pix <= '0;
                else if (scaled > PMAX) o_pix <= PIX_W'(PMAX);
                else                    o_pix <= PIX_W'(scaled);
            end
        end
    end
endmodule

// File: rtl/sharpen3x3.sv
module sharpen3x3
    import sharp_pkg::*;
#(
    parameter int LINE_W  = 64,
    parameter int FRAME_H = 32,
    parameter int ACC_W   = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_sof,
    input  logic       in_sol,
    input  logic       in_eol,
    input  logic [7:0] in_pix,
    output logic       out_valid,
    output logic       out_sol,
    output logic       out_eol,
    output logic [7:0] out_pix
);
    localparam int CW   = $clog2(LINE_W + 1);
    localparam int AW   = $clog2(LINE_W);
    localparam int RW   = $clog2(FRAME_H + 2);
    localparam int TAPS = 2;
    localparam logic [RW-1:0] ROW_ONE  = RW'(1);
    localparam logic [RW-1:0] ROW_LAST = RW'(FRAME_H);
    localparam logic [RW-1:0] ROW_DONE = RW'(FRAME_H + 1);
    localparam logic [CW-1:0] COL_END  = CW'(LINE_W - 1);
    localparam logic [CW-1:0] COL_ONE  = CW'(1);

    st_t st_q, st_d;
    logic [CW-1:0] col_q, cidx;
    logic [RW-1:0] row_q;
    logic take, col_ev, is_tail, is_drain, ev_out, ev_sol;
    logic [TAPS*PIX_W-1:0] taps;
    pix_t prev1, prev2;
    colv_t vec, win_prv, win_cur, rgt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (in_valid && in_sof && in_sol) st_d = ST_PRIME;
            ST_PRIME:  if (in_valid && in_eol) st_d = ST_STREAM;
            ST_STREAM: if (in_valid && in_eol) st_d = ST_TAIL;
            ST_TAIL: begin
                if (row_q == ROW_LAST)      st_d = ST_DRAIN;
                else if (row_q == ROW_DONE) st_d = ST_IDLE;
                else                        st_d = ST_STREAM;
            end
            ST_DRAIN:  if (col_q == COL_END) st_d = ST_TAIL;
            default:   st_d = ST_IDLE;
        endcase
    end

    // per-state controls
    always_comb begin
        take     = 1'b0;
        col_ev   = 1'b0;
        is_tail  = 1'b0;
        is_drain = 1'b0;
        unique case (st_q)
            ST_IDLE:   take = in_valid && in_sof && in_sol;
            ST_PRIME:  take = in_valid;
            ST_STREAM: begin
                take   = in_valid;
                col_ev = in_valid;
            end
            ST_TAIL:   is_tail = 1'b1;
            ST_DRAIN: begin
                col_ev   = 1'b1;
                is_drain = 1'b1;
            end
            default: ;
        endcase
    end

    assign cidx = (is_drain || !in_sol) ? col_q : '0;

    // column and row position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
            row_q <= '0;
        end else begin
            if (take || col_ev) col_q <= cidx + COL_ONE;
            if (st_q == ST_TAIL) col_q <= '0;
            if (st_q == ST_IDLE && take) row_q <= '0;
            if (st_q == ST_PRIME && in_valid && in_eol) row_q <= ROW_ONE;
            if (st_q == ST_STREAM && in_valid && in_eol) row_q <= row_q + ROW_ONE;
            if (st_q == ST_DRAIN && col_q == COL_END) row_q <= row_q + ROW_ONE;
        end
    end

    sharp_linebuf #(
        .LINE_W (LINE_W),
        .DEPTH  (TAPS)
    ) u_lb (
        .clk  (clk),
        .we   (take),
        .addr (cidx[AW-1:0]),
        .din  (in_pix),
        .taps (taps)
    );

    assign prev1 = taps[0 +: PIX_W];
    assign prev2 = taps[PIX_W +: PIX_W];

    // vertical column, with top and bottom replication
    always_comb begin
        vec.mid = prev1;
        vec.dn  = is_drain ? prev1 : in_pix;
        vec.up  = (row_q == ROW_ONE && !is_drain) ? prev1 : prev2;
    end

    sharp_hwin u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (col_ev),
        .first (cidx == '0),
        .nv    (vec),
        .prv   (win_prv),
        .cur   (win_cur)
    );

    assign rgt    = is_tail ? win_cur : vec;
    assign ev_out = (col_ev && cidx != '0) || is_tail;
    assign ev_sol = col_ev && cidx == COL_ONE;

    sharp_mac #(
        .ACC_W (ACC_W)
    ) u_mac (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_vld (ev_out),
        .in_sol (ev_sol),
        .in_eol (is_tail),
        .lft    (win_prv),
        .ctr    (win_cur),
        .rgt    (rgt),
        .o_vld  (out_valid),
        .o_sol  (out_sol),
        .o_eol  (out_eol),
        .o_pix  (out_pix)
    );
endmodule

// File: rtl/sharpen3x3_chk.sv
module sharpen3x3_chk
    import sharp_pkg::*;
#(
    parameter int LINE_W = 64
) (
    input logic clk,
    input logic rst_n,
    input logic out_valid,
    input logic out_sol,
    input logic out_eol,
    input logic ev_out,
    input st_t  st
);
    int pix_cnt;
    int idle_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_cnt  <= 0;
            idle_run <= 0;
        end else begin
            if (out_valid) pix_cnt <= out_sol ? 1 : pix_cnt + 1;
            if (st != ST_IDLE)  idle_run <= 0;
            else if (idle_run < 3) idle_run <= idle_run + 1;
        end
    end

    // R6
    sol_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sol |-> out_valid);

    // R6
    eol_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_eol |-> out_valid);

    // R6
    line_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_eol |-> (pix_cnt == LINE_W - 1));

    // R8
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_out |-> ##2 out_valid);

    // R9
    eol_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_eol |=> !out_valid);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && idle_run >= 2) |-> !out_valid);
endmodule

bind sharpen3x3 sharpen3x3_chk #(.LINE_W(LINE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_sol   (out_sol),
    .out_eol   (out_eol),
    .ev_out    (ev_out),
    .st        (st_q)
);

// File: tb/tb_sharpen3x3.sv
module tb_sharpen3x3;
    localparam int W = 8;
    localparam int H = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sof = 1'b0, in_sol = 1'b0, in_eol = 1'b0;
    logic [7:0] in_pix = '0;
    logic out_valid, out_sol, out_eol;
    logic [7:0] out_pix;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int img [H][W];
    int drv_cyc [H][W];
    int orow, ocol, fcount;
    bit mon_en = 0;
    bit sat_frame = 0;
    bit prev_eol = 0;
    int junk_out = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sharpen3x3 #(.LINE_W(W), .FRAME_H(H)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_sol(in_sol), .in_eol(in_eol), .in_pix(in_pix),
        .out_valid(out_valid), .out_sol(out_sol), .out_eol(out_eol), .out_pix(out_pix)
    );

    function automatic int px(int r, int c);
        int rr = (r < 0) ? 0 : ((r > H - 1) ? H - 1 : r);
        int cc = (c < 0) ? 0 : ((c > W - 1) ? W - 1 : c);
        return img[rr][cc];
    endfunction

    function automatic int expect_px(int r, int c);
        int a, v;
        a = 4096 * px(r, c)
          - 630 * (px(r-1, c) + px(r+1, c) + px(r, c-1) + px(r, c+1))
          - 158 * (px(r-1, c-1) + px(r-1, c+1) + px(r+1, c-1) + px(r+1, c+1));
        v = (a + 512) >>> 10;
        if (v < 0) v = 0;
        if (v > 255) v = 255;
        return v;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0d)", req, act, exp, cyc);
        end
    endtask

    // output monitor, sampled on the falling edge
    always @(negedge clk) begin
        if (rst_n && prev_eol) check(!out_valid, "R9 gap after eol", int'(out_valid), 0);
        prev_eol <= out_valid && out_eol;
        if (rst_n && out_valid && !mon_en) junk_out++;
        if (mon_en && out_valid) begin
            string tag;
            if (sat_frame) tag = "R3 clamp";
            else if (orow == 0 || orow == H - 1) tag = "R5 row edge";
            else if (ocol == 0 || ocol == W - 1) tag = "R4 column edge";
            else tag = "R2 interior";
            check(int'(out_pix) == expect_px(orow, ocol), tag, int'(out_pix), expect_px(orow, ocol));
            check(out_sol == (ocol == 0), "R6 sol marker", int'(out_sol), int'(ocol == 0));
            check(out_eol == (ocol == W - 1), "R6 eol marker", int'(out_eol), int'(ocol == W - 1));
            if (orow < H - 1 && ocol < W - 1)
                check(cyc == drv_cyc[orow+1][ocol+1] + 2, "R8 latency",
                      cyc - drv_cyc[orow+1][ocol+1], 2);
            fcount++;
            if (ocol == W - 1) begin
                ocol = 0;
                orow++;
            end else begin
                ocol++;
            end
        end
    end

    task automatic run_frame(bit gaps);
        orow = 0;
        ocol = 0;
        fcount = 0;
        mon_en = 1;
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                if (gaps && ((r * 3 + c * 5) % 4 == 1)) begin
                    @(negedge clk);
                    in_valid = 1'b0;
                    in_pix = 8'hA5;
                end
                @(negedge clk);
                in_valid = 1'b1;
                in_sof = (r == 0 && c == 0);
                in_sol = (c == 0);
                in_eol = (c == W - 1);
                in_pix = 8'(img[r][c]);
                drv_cyc[r][c] = cyc;
            end
            @(negedge clk);
            in_valid = 1'b0;
            in_sof = 1'b0;
            in_sol = 1'b0;
            in_eol = 1'b0;
        end
        for (int k = 0; k < 200 && fcount < H * W; k++) @(negedge clk);
        // R6: full frame of outputs
        check(fcount == H * W, "R6 frame count", fcount, H * W);
        repeat (4) @(negedge clk);
        mon_en = 0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: quiet in reset
        check(out_valid == 0 && out_sol == 0 && out_eol == 0, "R1 in reset",
              int'({out_valid, out_sol, out_eol}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 0 && out_sol == 0 && out_eol == 0, "R1 after reset",
              int'({out_valid, out_sol, out_eol}), 0);

        // R7: pixels without a frame start are dropped
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sof = (k % 3 == 1);
            in_sol = (k % 3 == 2) || (k % 4 == 0);
            in_sof = in_sof && !in_sol;
            in_eol = (k % 5 == 4);
            in_pix = 8'(k * 19);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sof = 1'b0;
        in_sol = 1'b0;
        in_eol = 1'b0;
        repeat (20) @(negedge clk);
        check(junk_out == 0, "R7 idle ignores stray pixels", junk_out, 0);

        // R2: ramp pattern
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++) img[r][c] = (r * 37 + c * 29) % 256;
        run_frame(0);

        // R3: checkerboard of extremes
        sat_frame = 1;
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++) img[r][c] = ((r + c) % 2 == 0) ? 255 : 0;
        run_frame(0);
        sat_frame = 0;

        // R2: flat field
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++) img[r][c] = 200;
        run_frame(0);

        // R4 R5: bright corners on dark
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++) img[r][c] = 10;
        img[0][0] = 250;
        img[0][W-1] = 180;
        img[H-1][0] = 140;
        img[H-1][W-1] = 220;
        run_frame(0);

        // R8: pseudo-random content with valid dropouts
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++) img[r][c] = ((r * 7 + c * 13) * 97 + 41) % 256;
        run_frame(1);

        // R7: stray pixels after the frame still ignored
        check(junk_out == 0, "R7 no output outside frames", junk_out, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule